// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Software Acknowledge

The controller collects level-sensitive request lines from several devices and drives one interrupt line towards the CPU. A request counts only when software has enabled its line. When nothing is outstanding, the controller picks the enabled, asserted line with the lowest index. It raises the CPU interrupt and presents that line's index as a vector number. The CPU uses the number to select its handler.

Once an interrupt is issued, the controller is locked. It issues nothing more until the handler writes a fixed acknowledge code to the acknowledge port. Requests that lose arbitration, or that arrive while the controller is locked, are not stored. A device keeps its line asserted until it is serviced. After each acknowledge the controller arbitrates again, using the line levels present at that time. Software sets the enable mask and writes the acknowledge through one small register write port.

Top module: `intc_core`

## Requirements
- R1: After reset the CPU interrupt output is low, the vector output is 0 and every line is disabled, so asserted requests raise no interrupt.
- R2: A line whose enable bit is 0 never causes an interrupt, even while it is asserted.
- R3: While no interrupt is outstanding, an asserted enabled line sets the interrupt output high at the next clock edge.
- R4: When several enabled lines are asserted together, line 0 has the highest priority and line N-1 the lowest. The vector output equals the index of the winning line.
- R5: While an interrupt is outstanding, the interrupt output stays high and the vector output stays unchanged, whatever the request lines or mask writes do.
- R6: A write of the acknowledge code 0x20 to address 1 while an interrupt is outstanding drives the interrupt output low after that clock edge.
- R7: A write of any other value to address 1 has no effect on the interrupt output or the vector output.
- R8: An acknowledge write while no interrupt is outstanding is ignored: the outputs are unchanged, and a later request is issued normally.
- R9: At the first clock edge after an accepted acknowledge, arbitration runs again on the current line levels, so a request that is still held is issued then.
- R10: Requests are not latched: a line that drops before the lock is released is not issued afterwards.
- R11: A write to address 0 loads the enable mask from the low N bits of the write data (bit i enables line i). The new mask applies from the following cycle. Writes to addresses 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_req | input | N_LINES | Level request line from each device |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 selects the enable mask, 1 the acknowledge port |
| reg_wdata | input | DATA_W | Write data |
| cpu_irq | output | 1 | Interrupt request to the CPU, a registered level |
| cpu_vec | output | VEC_W | Index of the line being serviced |

## Verification
An accepted acknowledge and a fresh arbitration can meet: after the acknowledge edge, the next edge arbitrates on whatever lines are high. The bench holds all lines high, acknowledges, and expects one low cycle followed by the lowest enabled index. It repeats this after dropping the winner's line, and then expects the next line rather than the stale one. A mask write and a request can also land in the same cycle. The bench drives both on the same edge and expects the issue one cycle later, because that edge still arbitrates with the old mask. A reference model checks every cycle; directed checks then confirm the exact cycle of each edge.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HELD = 1'b1
  } issue_state_e;

  localparam int unsigned MASK_PORT = 0;
  localparam int unsigned ACK_PORT  = 1;

endpackage

// File: rtl/intc_rst_sync.sv
`timescale 1ns/1ps
module intc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/intc_wr_decode.sv
`timescale 1ns/1ps
module intc_wr_decode #(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ACK_CODE = 32'h20
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              mask_we,
  output logic              ack_hit
);

  import intc_pkg::*;

  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_PORT);
  localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_PORT);
  localparam logic [DATA_W-1:0] CODE   = DATA_W'(ACK_CODE);

  always_comb begin
    mask_we = we && (addr == MASK_A);
    ack_hit = we && (addr == ACK_A) && (wdata == CODE);
  end

endmodule

// File: rtl/intc_mask_reg.sv
`timescale 1ns/1ps
module intc_mask_reg #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DATA_W-1:0]  wdata,
  output logic [N_LINES-1:0] mask
);

  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (load) mask_d = wdata[N_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (load) mask_q <= mask_d;
  end

  assign mask = mask_q;

endmodule

// File: rtl/intc_prio_pick.sv
`timescale 1ns/1ps
module intc_prio_pick #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned VEC_W   = 3
) (
  input  logic [N_LINES-1:0] pend,
  output logic               any,
  output logic [VEC_W-1:0]   win
);

  logic [N_LINES-1:0] above;
  logic [N_LINES-1:0] grant;

  assign above[0] = 1'b0;
  assign grant[0] = pend[0];

  for (genvar g = 1; g < N_LINES; g++) begin : g_chain
    assign above[g] = above[g-1] | pend[g-1];
    assign grant[g] = pend[g] & ~above[g];
  end

  always_comb begin
    win = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (grant[i]) win = win | VEC_W'(i);
    end
  end

  assign any = |pend;

endmodule

// File: rtl/intc_issue_ctrl.sv
`timescale 1ns/1ps
module intc_issue_ctrl #(
  parameter int unsigned VEC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_pend,
  input  logic [VEC_W-1:0] win,
  input  logic             ack_hit,
  output logic             irq,
  output logic [VEC_W-1:0] vec
);

  import intc_pkg::*;

  issue_state_e     st_q, st_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vec_en;

  always_comb begin
    st_d   = st_q;
    vec_d  = vec_q;
    vec_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (any_pend) begin
          st_d   = ST_HELD;
          vec_d  = win;
          vec_en = 1'b1;
        end
      end
      ST_HELD: begin
        if (ack_hit) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  assign irq = (st_q == ST_HELD);
  assign vec = vec_q;

endmodule

// File: rtl/intc_core.sv
`timescale 1ns/1ps
module intc_core #(
  parameter int unsigned N_LINES  = 8,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ACK_CODE = 32'h20,
  localparam int unsigned VEC_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] dev_req,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic               cpu_irq,
  output logic [VEC_W-1:0]   cpu_vec
);

  logic               rst_n_int;
  logic               mask_we;
  logic               ack_hit;
  logic [N_LINES-1:0] line_en;
  logic [N_LINES-1:0] pend;
  logic               any_pend;
  logic [VEC_W-1:0]   win;

  intc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_int)
  );

  intc_wr_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ACK_CODE(ACK_CODE)
  ) u_dec (
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .mask_we(mask_we),
    .ack_hit(ack_hit)
  );

  intc_mask_reg #(
    .N_LINES(N_LINES),
    .DATA_W (DATA_W)
  ) u_mask (
    .clk  (clk),
    .rst_n(rst_n_int),
    .load (mask_we),
    .wdata(reg_wdata),
    .mask (line_en)
  );

  assign pend = dev_req & line_en;

  intc_prio_pick #(
    .N_LINES(N_LINES),
    .VEC_W  (VEC_W)
  ) u_pick (
    .pend(pend),
    .any (any_pend),
    .win (win)
  );

  intc_issue_ctrl #(.VEC_W(VEC_W)) u_issue (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .any_pend(any_pend),
    .win     (win),
    .ack_hit (ack_hit),
    .irq     (cpu_irq),
    .vec     (cpu_vec)
  );

endmodule

// File: rtl/intc_core_chk.sv
`timescale 1ns/1ps
module intc_core_chk #(
  parameter int unsigned N_LINES  = 8,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ACK_CODE = 32'h20,
  parameter int unsigned VEC_W    = 3
) (
  input logic               clk,
  input logic               rst_n_int,
  input logic [N_LINES-1:0] dev_req,
  input logic [N_LINES-1:0] line_en,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               cpu_irq,
  input logic [VEC_W-1:0]   cpu_vec
);

  logic               ack_wr;
  logic               other_wr;
  logic [N_LINES-1:0] live;
  logic [N_LINES-1:0] live_prev;
  logic [N_LINES-1:0] lower;

  assign ack_wr   = reg_we && (reg_addr == ADDR_W'(1)) && (reg_wdata == DATA_W'(ACK_CODE));
  assign other_wr = reg_we && (reg_addr == ADDR_W'(1)) && (reg_wdata != DATA_W'(ACK_CODE));
  assign live     = dev_req & line_en;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) live_prev <= '0;
    else            live_prev <= live;
  end

  always_comb begin
    for (int i = 0; i < N_LINES; i++) lower[i] = (i < int'(cpu_vec));
  end

  p_issue_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!cpu_irq && (|live)) |=> cpu_irq);

  p_source_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(cpu_irq) |-> live_prev[cpu_vec]);

  p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(cpu_irq) |-> ((live_prev & lower) == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cpu_irq && !ack_wr) |=> cpu_irq);

  p_vec_stable_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cpu_irq && $past(cpu_irq)) |-> $stable(cpu_vec));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cpu_irq && ack_wr) |=> !cpu_irq);

  p_bad_code_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cpu_irq && other_wr) |=> (cpu_irq && $stable(cpu_vec)));

  p_idle_ack_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!cpu_irq && ack_wr && !(|live)) |=> (!cpu_irq && $stable(cpu_vec)));

endmodule

bind intc_core intc_core_chk #(
  .N_LINES (N_LINES),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .ACK_CODE(ACK_CODE),
  .VEC_W   (VEC_W)
) u_chk (
  .clk      (clk),
  .rst_n_int(rst_n_int),
  .dev_req  (dev_req),
  .line_en  (line_en),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .cpu_irq  (cpu_irq),
  .cpu_vec  (cpu_vec)
);

// File: tb/tb_intc_core.sv
`timescale 1ns/1ps
module tb_intc_core;

  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] dev_req;
  logic         reg_we;
  logic [1:0]   reg_addr;
  logic [7:0]   reg_wdata;
  logic         cpu_irq;
  logic [2:0]   cpu_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase = "R1";

  intc_core dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_req  (dev_req),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .cpu_irq  (cpu_irq),
    .cpu_vec  (cpu_vec)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // behavioural reference model
  bit     m_irq;
  int     m_vec;
  bit [7:0] m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irq  <= 0;
      m_vec  <= 0;
      m_mask <= 0;
    end else begin
      if (m_irq) begin
        if (reg_we && reg_addr == 1 && reg_wdata == 8'h20) m_irq <= 0;
      end else begin
        int pick;
        pick = -1;
        for (int i = N - 1; i >= 0; i--)
          if (dev_req[i] && m_mask[i]) pick = i;
        if (pick >= 0) begin
          m_irq <= 1;
          m_vec <= pick;
        end
      end
      if (reg_we && reg_addr == 0) m_mask <= reg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (cpu_irq !== m_irq || int'(cpu_vec) != m_vec) begin
        fails++;
        $display("FAIL %s model: irq=%0b vec=%0d expected irq=%0b vec=%0d",
                 phase, cpu_irq, cpu_vec, m_irq, m_vec);
      end
    end
  end

  task automatic expect_out(input string req, input bit irq, input int vec);
    checks++;
    if (cpu_irq !== irq || int'(cpu_vec) != vec) begin
      fails++;
      $display("FAIL %s: irq=%0b vec=%0d expected irq=%0b vec=%0d",
               req, cpu_irq, cpu_vec, irq, vec);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; dev_req = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    cyc(3);
    rst_n = 1;
    cyc(4);
    phase = "R1"; expect_out("R1", 0, 0);
    dev_req = 8'hFF; cyc(3);
    expect_out("R1", 0, 0);

    phase = "R2"; dev_req = 8'h00;
    wr(0, 8'hF0);
    dev_req = 8'h0F; cyc(2);
    expect_out("R2", 0, 0);

    phase = "R3"; dev_req = 8'h30; cyc(1);
    expect_out("R3", 1, 4);
    expect_out("R4", 1, 4);

    phase = "R5"; dev_req = 8'hFF;
    wr(0, 8'hFF); cyc(1);
    expect_out("R5", 1, 4);

    phase = "R7"; wr(1, 8'h21); cyc(1);
    expect_out("R7", 1, 4);

    phase = "R6"; wr(1, 8'h20);
    expect_out("R6", 0, 4);
    phase = "R9"; cyc(1);
    expect_out("R9", 1, 0);

    phase = "R10"; dev_req = 8'h02; cyc(1);
    wr(1, 8'h20);
    expect_out("R6", 0, 0);
    cyc(1);
    expect_out("R10", 1, 1);

    phase = "R8"; dev_req = 8'h00;
    wr(1, 8'h20); cyc(1);
    expect_out("R8", 0, 1);
    wr(1, 8'h20); cyc(1);
    expect_out("R8", 0, 1);
    dev_req = 8'h80; cyc(1);
    expect_out("R8", 1, 7);

    phase = "R11"; dev_req = 8'h00;
    wr(2, 8'h00);
    wr(3, 8'h00);
    wr(1, 8'h20); cyc(1);
    dev_req = 8'h01; cyc(1);
    expect_out("R11", 1, 0);
    dev_req = 8'h00;
    wr(1, 8'h20);
    wr(0, 8'h00);
    dev_req = 8'hFF; cyc(2);
    expect_out("R11", 0, 0);
    dev_req = 8'h04;
    wr(0, 8'h04);
    expect_out("R11", 0, 0);
    cyc(1);
    expect_out("R11", 1, 2);
    cyc(2);

    finish_run();
  end

endmodule